// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow flags

This block is a purely combinational arithmetic-logic unit. It takes two 16-bit operands and a 3-bit operation code. It returns a 16-bit result and two overflow flags, one for an unsigned reading of the operands and one for a signed reading. The caller picks the flag that matches how it interprets its numbers.

The operations are bitwise OR and AND, add, subtract, three shifts and a signed less-than test. The add and subtract share one adder stage. That stage also supplies the less-than answer, so the comparison stays correct when the difference wraps. The shifts run through a staged barrel shifter that is driven by the low four bits of the second operand.

The block has no clock, no reset and no handshake. The outputs follow the inputs after logic delay only. Because no data stream crosses a registered boundary, no valid/ready protocol is used and no back-pressure rule applies.

Top module: `alu16`

## Requirements
- R1: `op_sel` 000 gives `opa | opb` and 001 gives `opa & opb`.
- R2: `op_sel` 010 gives `opa + opb` modulo 2^16.
- R3: `op_sel` 011 gives `opa - opb` modulo 2^16.
- R4: `ovf_unsigned` is 1 exactly when `op_sel` is 010 and the unsigned sum exceeds 16'hFFFF. It is 0 for every other code, including subtract.
- R5: `ovf_signed` is 1 exactly when `op_sel` is 010 or 011 and the true two's-complement result lies outside -32768..32767. It is 0 for every other code.
- R6: For codes 100, 101 and 110 the shift distance is `opb[3:0]`, and `opb[15:4]` has no effect on any output.
- R7: `op_sel` 100 shifts `opa` left and fills the vacated low bits with zeros.
- R8: `op_sel` 101 shifts `opa` right and fills the vacated high bits with zeros.
- R9: `op_sel` 110 shifts `opa` right and fills the vacated high bits with copies of `opa[15]`.
- R10: `op_sel` 111 gives 16'h0001 when signed `opa` < signed `opb`, otherwise 16'h0000. This holds even when `opa - opb` overflows.
- R11: All outputs are a pure function of the present inputs. They show no dependence on earlier inputs and hold no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | First operand, bit 0 least significant |
| opb | input | 16 | Second operand; low 4 bits give the shift distance |
| op_sel | input | 3 | Operation code |
| result | output | 16 | Operation result |
| ovf_unsigned | output | 1 | Unsigned overflow, set for add only |
| ovf_signed | output | 1 | Signed overflow, set for add or subtract |

## Verification
Every result and flag is due in the same cycle as its stimulus, zero clock edges later. The bench drives the operands on the falling edge of its reference clock and samples one nanosecond later, well before the next rising edge. At that point the combinational paths have settled and no edge lies in between. Because successive vectors are unrelated random values, any stale or remembered value would appear as a mismatch against the bench's reference functions.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_OR  = 3'b000,
    OP_AND = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_SLL = 3'b100,
    OP_SRL = 3'b101,
    OP_SRA = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             sum_ovf,
  output logic [WIDTH-1:0] diff,
  output logic             diff_ovf,
  output logic             less
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] sum_ext;

  assign sum_ext  = {1'b0, a} + {1'b0, b};
  assign sum      = sum_ext[MSB:0];
  assign carry    = sum_ext[WIDTH];
  assign diff     = a - b;
  // like signs yielding an unlike sign
  assign sum_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  // unlike signs, result sign departs from minuend
  assign diff_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
  // sign of the difference, corrected when it wrapped
  assign less     = diff[MSB] ^ diff_ovf;
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  input  shift_mode_e      mode,
  output logic [WIDTH-1:0] dout
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] stage [0:SHW];
  logic             fill;

  assign fill     = (mode == SH_RARI) && din[MSB];
  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      if (mode == SH_LEFT)
        moved = {stage[k][MSB-STEP:0], {STEP{1'b0}}};
      else
        moved = {{STEP{fill}}, stage[k][MSB:STEP]};
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf_unsigned,
  output logic             ovf_signed
);
  localparam int SHW = $clog2(WIDTH);

  alu_op_e          op;
  shift_mode_e      smode;
  logic [WIDTH-1:0] sum, diff, shifted;
  logic             carry, sum_ovf, diff_ovf, less;

  assign op = alu_op_e'(op_sel);

  alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opa), .b(opb), .sum(sum), .carry(carry), .sum_ovf(sum_ovf),
    .diff(diff), .diff_ovf(diff_ovf), .less(less)
  );

  always_comb begin
    unique case (op)
      OP_SRL:  smode = SH_RLOG;
      OP_SRA:  smode = SH_RARI;
      default: smode = SH_LEFT;
    endcase
  end

  alu16_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .din(opa), .amt(opb[SHW-1:0]), .mode(smode), .dout(shifted)
  );

  always_comb begin
    result       = '0;
    ovf_unsigned = 1'b0;
    ovf_signed   = 1'b0;
    unique case (op)
      OP_OR:  result = opa | opb;
      OP_AND: result = opa & opb;
      OP_ADD: begin
        result       = sum;
        ovf_unsigned = carry;
        ovf_signed   = sum_ovf;
      end
      OP_SUB: begin
        result     = diff;
        ovf_signed = diff_ovf;
      end
      OP_SLL, OP_SRL, OP_SRA: result = shifted;
      OP_SLT: result = {{(WIDTH-1){1'b0}}, less};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf_unsigned,
  input logic             ovf_signed
);
  always_comb begin
    // R4
    uovf_op_chk: assert (!ovf_unsigned || op_sel == 3'b010);
    // R4
    uovf_wrap_chk: assert (!(op_sel == 3'b010 && ovf_unsigned) || (result < opa));
    // R5
    sovf_op_chk: assert (!ovf_signed || op_sel == 3'b010 || op_sel == 3'b011);
    // R8
    srl_top_chk: assert (!(op_sel == 3'b101 && opb[3:0] != 4'd0) || !result[WIDTH-1]);
    // R9
    sra_sign_chk: assert (op_sel != 3'b110 || result[WIDTH-1] == opa[WIDTH-1]);
    // R10
    slt_shape_chk: assert (op_sel != 3'b111 || result[WIDTH-1:1] == '0);
  end
endmodule

bind alu16 alu16_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu16_test.sv
module alu16_test;
  logic        clk = 1'b0;
  logic [15:0] opa, opb, result;
  logic [2:0]  op_sel;
  logic        ovf_unsigned, ovf_signed;
  int          total = 0;
  int          bad   = 0;
  bit          timed_out = 1'b0;

  always #2.5 clk = ~clk;

  alu16 uut (
    .opa(opa), .opb(opb), .op_sel(op_sel),
    .result(result), .ovf_unsigned(ovf_unsigned), .ovf_signed(ovf_signed)
  );

  function automatic logic [17:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [2:0] op);
    logic [16:0] wide;
    int          s;
    logic [15:0] r  = '0;
    logic        fu = 1'b0;
    logic        fs = 1'b0;
    case (op)
      3'b000: r = a | b;
      3'b001: r = a & b;
      3'b010: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[15:0]; fu = wide[16];
        s = int'($signed(a)) + int'($signed(b));
        fs = (s > 32767) || (s < -32768);
      end
      3'b011: begin
        r = a - b;
        s = int'($signed(a)) - int'($signed(b));
        fs = (s > 32767) || (s < -32768);
      end
      3'b100: r = a << b[3:0];
      3'b101: r = a >> b[3:0];
      3'b110: r = $unsigned($signed(a) >>> b[3:0]);
      default: r = ($signed(a) < $signed(b)) ? 16'h0001 : 16'h0000;
    endcase
    return {r, fu, fs};
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'b000, 3'b001: return "R1";
      3'b010: return "R2";
      3'b011: return "R3";
      3'b100: return "R7";
      3'b101: return "R8";
      3'b110: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op);
    logic [17:0] exp;
    @(negedge clk);
    opa = a; opb = b; op_sel = op;
    #1;
    exp = model(a, b, op);
    total++;
    if (result !== exp[17:2]) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", tag(op), op, a, b, result, exp[17:2]);
    end
    total++;
    if (ovf_unsigned !== exp[1]) begin
      bad++;
      $display("FAIL R4 op=%b a=%h b=%h ovf_unsigned actual=%b expected=%b", op, a, b, ovf_unsigned, exp[1]);
    end
    total++;
    if (ovf_signed !== exp[0]) begin
      bad++;
      $display("FAIL R5 op=%b a=%h b=%h ovf_signed actual=%b expected=%b", op, a, b, ovf_signed, exp[0]);
    end
  endtask

  // R6: upper opb bits must not change a shift outcome
  task automatic shift_ignore(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op);
    logic [15:0] r0;
    @(negedge clk);
    opa = a; opb = {12'h000, b[3:0]}; op_sel = op;
    #1;
    r0 = result;
    opb = b;
    #1;
    total++;
    if (result !== r0 || ovf_unsigned !== 1'b0 || ovf_signed !== 1'b0) begin
      bad++;
      $display("FAIL R6 op=%b a=%h b=%h result actual=%h expected=%h", op, a, b, result, r0);
    end
  endtask

  initial begin
    #100000;
    timed_out = 1'b1;
  end

  initial begin
    void'($urandom(32'd2024));
    opa = '0; opb = '0; op_sel = '0;
    #1;
    total++;  // settled state with all inputs at zero, R11
    if (result !== 16'h0 || ovf_unsigned !== 1'b0 || ovf_signed !== 1'b0) begin
      bad++;
      $display("FAIL R11 zero inputs result actual=%h expected=0000", result);
    end
    // directed corners
    run(16'hFFFF, 16'h0001, 3'b010);  // R4 carry out
    run(16'h7FFF, 16'h0001, 3'b010);  // R5 positive overflow
    run(16'h8000, 16'h8000, 3'b010);  // R4 and R5 together
    run(16'h8000, 16'h0001, 3'b011);  // R5 subtract overflow
    run(16'h0000, 16'h0001, 3'b011);  // R3 borrow, no R4 flag
    run(16'h7FFF, 16'h8000, 3'b011);  // R5
    run(16'h8000, 16'h7FFF, 3'b111);  // R10 with wrapped difference
    run(16'h7FFF, 16'h8000, 3'b111);  // R10
    run(16'h1234, 16'h1234, 3'b111);  // R10 equal
    run(16'h8001, 16'h000F, 3'b100);  // R7 maximal distance
    run(16'h8001, 16'h000F, 3'b101);  // R8
    run(16'h8001, 16'h000F, 3'b110);  // R9
    run(16'h4000, 16'h0003, 3'b110);  // R9 positive fill
    run(16'hF0F0, 16'h0FF0, 3'b000);  // R1
    run(16'hF0F0, 16'h0FF0, 3'b001);  // R1
    shift_ignore(16'hA5C3, 16'hFFF5, 3'b100);
    shift_ignore(16'hA5C3, 16'h8A03, 3'b101);
    shift_ignore(16'hA5C3, 16'h1230, 3'b110);
    for (int i = 0; i < 3000 && !timed_out; i++) begin
      run(16'($urandom), 16'($urandom), 3'($urandom));  // R11: successive vectors unrelated
    end
    for (int i = 0; i < 60 && !timed_out; i++) begin
      shift_ignore(16'($urandom), 16'($urandom), 3'(4 + ($urandom % 3)));
    end
    if (timed_out) begin
      total++; bad++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule